// File: doc/BRIEF.md
# Four-Channel DMA Controller

This block moves data between I/O devices and memory on behalf of the CPU. It has four channels. Each channel holds a programmed start address and block length, a mode (transfer direction, address step direction, automatic reload) and a mask bit. A device asks for service by raising its request line. Software can also post a request for a channel through the programming port.

When an unmasked channel has a request pending, the controller asks the CPU for the bus by raising `hold` and waits for `hlda`. It then serves the highest-priority pending channel with one transfer. During that transfer it drives the channel's current address, acknowledges the device on its `dack` line, and pulses the paired memory and I/O strobes for one cycle. Afterwards it steps the address, decrements the count and hands the bus back. A channel's block ends in one of two ways: its count runs out, or the device pulls `eop_n` low during a strobe cycle. At that point the controller pulses `done`, sets the channel's terminal-count flag, and either masks the channel or reloads its start values.

Top module: `dma4_ctrl`

## Requirements
- R1: Each of the four channels has its own request input and acknowledge output. At most one `dack` bit is high at a time. It is high only during the address cycle and the strobe cycle of a transfer for that channel, and it holds the same value through both cycles.
- R2: A channel whose mask bit is set (select code 3, data bit 0 = 1) is never served, whatever its request lines do. Clearing the mask lets a pending request be served. All masks are set by reset.
- R3: The controller raises `hold` when an unmasked request is pending. It drives no strobe until `hlda` has been seen. It drops `hold` after every single transfer.
- R4: Select code 0 loads the start address and current address. Select code 1 loads the start count and current count. A block is count+1 transfers. In increment mode each transfer uses the previous address plus one, wrapping at 16 bits.
- R5: With mode bit 1 set (mode is select code 2), each transfer uses the previous address minus one, wrapping at 16 bits.
- R6: With mode bit 2 set, a channel that ends its block reloads its start address and count and keeps its mask clear, so the next block repeats the same addresses.
- R7: When a channel's count passes from zero to all-ones, the controller pulses `done` for one cycle and sets `tc_stat` for that channel. Unless auto-reload is on, it also sets the channel's mask. Writing the count (select code 1) clears that channel's `tc_stat` bit.
- R8: If `eop_n` is low in the strobe cycle of a transfer, the block ends after that transfer, exactly as at terminal count.
- R9: Select code 4 with data bit 0 = 1 posts a software request. It starts transfers with no hardware request and is cleared when the channel's block ends.
- R10: When several unmasked channels are pending, channel 0 wins over 1, 1 over 2, and 2 over 3.
- R11: Mode bit 0 = 0 (device to memory) pulses `io_rd_n` and `mem_wr_n` low together. Mode bit 0 = 1 (memory to device) pulses `mem_rd_n` and `io_wr_n` low together. Each strobe cycle is exactly one clock long.
- R12: After reset, `hold`, `dack`, `done` and `tc_stat` are zero, all strobes are high, and `mask_stat` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| prog_we | input | 1 | Programming write strobe |
| prog_chan | input | 2 | Channel addressed by the write |
| prog_sel | input | 3 | Field: 0 address, 1 count, 2 mode, 3 mask, 4 software request |
| prog_data | input | 16 | Write data |
| dreq | input | 4 | Device request, one per channel |
| dack | output | 4 | Device acknowledge, one per channel |
| hold | output | 1 | Bus request to the CPU |
| hlda | input | 1 | Bus grant from the CPU |
| addr | output | 16 | Transfer address, zero when not driving the bus |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | I/O read strobe, active low |
| io_wr_n | output | 1 | I/O write strobe, active low |
| eop_n | input | 1 | External end of block, active low |
| done | output | 1 | One-cycle pulse when a block ends |
| tc_stat | output | 4 | Sticky terminal-count flags |
| mask_stat | output | 4 | Current mask bits |

## Verification
The bench goes after several corner cases. The first is an address that steps down through zero to FFFF; a wrong wrap or step sign shows up as a bad address in the logged transfer list. The second is a one-transfer block: a design that ends a block at count zero rather than at the zero-to-all-ones step would make one transfer too few or too many. Next, the bench withholds `hlda` for many cycles, drops `eop_n` in the middle of a block, and raises two requests at once. A design that strobed before the grant, ignored the early end, or picked the wrong channel would log transfers the bench does not expect. Last, it checks that a software request or a masked request stops where it must, under auto-reload where no mask would hide the fault.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_HWAIT,
    S_ADDR,
    S_STRB,
    S_UPD
  } seq_st_t;

  typedef struct packed {
    logic autoinit;
    logic dec;
    logic to_dev;
  } chan_mode_t;

  localparam logic [2:0] SEL_ADDR = 3'd0;
  localparam logic [2:0] SEL_CNT  = 3'd1;
  localparam logic [2:0] SEL_MODE = 3'd2;
  localparam logic [2:0] SEL_MASK = 3'd3;
  localparam logic [2:0] SEL_SREQ = 3'd4;
endpackage

// File: rtl/dma4_chan.sv
module dma4_chan
  import dma4_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          upd,
  input  logic          eop_end,
  output logic [AW-1:0] cur_addr,
  output chan_mode_t    mode,
  output logic          mask,
  output logic          sreq,
  output logic          tc,
  output logic          term
);
  logic [AW-1:0] base_a_q, base_a_d, cur_a_q, cur_a_d;
  logic [CW-1:0] base_c_q, base_c_d, cur_c_q, cur_c_d;
  chan_mode_t    mode_q, mode_d;
  logic          mask_q, mask_d, sreq_q, sreq_d, tc_q, tc_d;
  logic          reg_en;

  assign term   = upd & ((cur_c_q == '0) | eop_end);
  assign reg_en = wr_en | upd;

  always_comb begin
    base_a_d = base_a_q;
    base_c_d = base_c_q;
    cur_a_d  = cur_a_q;
    cur_c_d  = cur_c_q;
    mode_d   = mode_q;
    mask_d   = mask_q;
    sreq_d   = sreq_q;
    tc_d     = tc_q;
    if (wr_en) begin
      case (wr_sel)
        SEL_ADDR: begin
          base_a_d = wr_data;
          cur_a_d  = wr_data;
        end
        SEL_CNT: begin
          base_c_d = wr_data[CW-1:0];
          cur_c_d  = wr_data[CW-1:0];
          tc_d     = 1'b0;
        end
        SEL_MODE: mode_d = chan_mode_t'(wr_data[2:0]);
        SEL_MASK: mask_d = wr_data[0];
        SEL_SREQ: sreq_d = wr_data[0];
        default: ;
      endcase
    end else if (upd) begin
      cur_a_d = mode_q.dec ? cur_a_q - 1'b1 : cur_a_q + 1'b1;
      cur_c_d = cur_c_q - 1'b1;
      if (term) begin
        tc_d   = 1'b1;
        sreq_d = 1'b0;
        if (mode_q.autoinit) begin
          cur_a_d = base_a_q;
          cur_c_d = base_c_q;
        end else begin
          mask_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_a_q <= '0;
      base_c_q <= '0;
      cur_a_q  <= '0;
      cur_c_q  <= '0;
      mode_q   <= '0;
      mask_q   <= 1'b1;
      sreq_q   <= 1'b0;
      tc_q     <= 1'b0;
    end else if (reg_en) begin
      base_a_q <= base_a_d;
      base_c_q <= base_c_d;
      cur_a_q  <= cur_a_d;
      cur_c_q  <= cur_c_d;
      mode_q   <= mode_d;
      mask_q   <= mask_d;
      sreq_q   <= sreq_d;
      tc_q     <= tc_d;
    end
  end

  assign cur_addr = cur_a_q;
  assign mode     = mode_q;
  assign mask     = mask_q;
  assign sreq     = sreq_q;
  assign tc       = tc_q;

  // R7
  tc_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (term && !wr_en && !mode_q.autoinit) |=> (mask_q && tc_q));

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !term && !wr_en) |=> (cur_c_q == CW'($past(cur_c_q) - 1'b1)));
endmodule

// File: rtl/dma4_prio.sv
module dma4_prio #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  output logic [NCH-1:0] gnt,
  output logic           any
);
  always_comb begin
    gnt = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) gnt = NCH'(1) << i;
    end
  end

  assign any = |req;

  // R10
  prio_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req[0] |-> gnt[0]);

  // R10
  prio_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> $onehot(gnt));
endmodule

// File: rtl/dma4_seq.sv
module dma4_seq
  import dma4_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pend_any,
  input  logic [NCH-1:0] gnt,
  input  logic [NCH-1:0] to_dev_vec,
  input  logic           hlda,
  input  logic           eop_n,
  output logic           hold,
  output logic [NCH-1:0] sel,
  output logic [NCH-1:0] dack,
  output logic [NCH-1:0] upd,
  output logic           bus_en,
  output logic           eop_end,
  output logic           mem_rd_n,
  output logic           mem_wr_n,
  output logic           io_rd_n,
  output logic           io_wr_n
);
  seq_st_t        st_q, st_d;
  logic [NCH-1:0] sel_q;
  logic           sel_en;
  logic           eop_q, eop_d;
  logic           strb, to_dev;

  always_comb begin
    st_d  = st_q;
    eop_d = eop_q;
    case (st_q)
      S_IDLE:  if (pend_any) st_d = S_HWAIT;
      S_HWAIT: begin
        if (!pend_any)  st_d = S_IDLE;
        else if (hlda)  st_d = S_ADDR;
      end
      S_ADDR:  st_d = S_STRB;
      S_STRB: begin
        st_d  = S_UPD;
        eop_d = ~eop_n;
      end
      S_UPD: begin
        st_d  = S_IDLE;
        eop_d = 1'b0;
      end
      default: st_d = S_IDLE;
    endcase
  end

  assign sel_en = (st_q == S_HWAIT) & hlda & pend_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      sel_q <= '0;
      eop_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      eop_q <= eop_d;
      if (sel_en) sel_q <= gnt;
    end
  end

  assign strb     = (st_q == S_STRB);
  assign to_dev   = |(sel_q & to_dev_vec);
  assign bus_en   = (st_q == S_ADDR) | strb;
  assign hold     = (st_q != S_IDLE);
  assign sel      = sel_q;
  assign dack     = bus_en ? sel_q : '0;
  assign upd      = (st_q == S_UPD) ? sel_q : '0;
  assign eop_end  = eop_q;
  assign mem_rd_n = ~(strb & to_dev);
  assign io_wr_n  = ~(strb & to_dev);
  assign mem_wr_n = ~(strb & ~to_dev);
  assign io_rd_n  = ~(strb & ~to_dev);

  // R3
  grant_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_ADDR) |-> $past(hlda));

  // R1
  dack_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack));

  // R11
  strb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd_n || !mem_wr_n) |=> (mem_rd_n && mem_wr_n));
endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
  import dma4_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           prog_we,
  input  logic [CHW-1:0] prog_chan,
  input  logic [2:0]     prog_sel,
  input  logic [AW-1:0]  prog_data,
  input  logic [NCH-1:0] dreq,
  output logic [NCH-1:0] dack,
  output logic           hold,
  input  logic           hlda,
  output logic [AW-1:0]  addr,
  output logic           mem_rd_n,
  output logic           mem_wr_n,
  output logic           io_rd_n,
  output logic           io_wr_n,
  input  logic           eop_n,
  output logic           done,
  output logic [NCH-1:0] tc_stat,
  output logic [NCH-1:0] mask_stat
);
  logic           rs0_q, rs1_q, rst_s_n;
  logic [NCH-1:0] sreq_vec, mask_vec, term_vec, to_dev_vec, pend;
  logic [NCH-1:0] gnt, sel, upd;
  logic           pend_any, bus_en, eop_end;
  logic [AW-1:0]  ch_addr [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs0_q <= 1'b0;
      rs1_q <= 1'b0;
    end else begin
      rs0_q <= 1'b1;
      rs1_q <= rs0_q;
    end
  end
  assign rst_s_n = rs1_q;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    chan_mode_t m;
    dma4_chan #(.AW(AW), .CW(CW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_s_n),
      .wr_en    (prog_we && (prog_chan == CHW'(g))),
      .wr_sel   (prog_sel),
      .wr_data  (prog_data),
      .upd      (upd[g]),
      .eop_end  (eop_end),
      .cur_addr (ch_addr[g]),
      .mode     (m),
      .mask     (mask_vec[g]),
      .sreq     (sreq_vec[g]),
      .tc       (tc_stat[g]),
      .term     (term_vec[g])
    );
    assign to_dev_vec[g] = m.to_dev;
  end

  assign pend = (dreq | sreq_vec) & ~mask_vec;

  dma4_prio #(.NCH(NCH)) u_prio (
    .clk   (clk),
    .rst_n (rst_s_n),
    .req   (pend),
    .gnt   (gnt),
    .any   (pend_any)
  );

  dma4_seq #(.NCH(NCH)) u_seq (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .pend_any   (pend_any),
    .gnt        (gnt),
    .to_dev_vec (to_dev_vec),
    .hlda       (hlda),
    .eop_n      (eop_n),
    .hold       (hold),
    .sel        (sel),
    .dack       (dack),
    .upd        (upd),
    .bus_en     (bus_en),
    .eop_end    (eop_end),
    .mem_rd_n   (mem_rd_n),
    .mem_wr_n   (mem_wr_n),
    .io_rd_n    (io_rd_n),
    .io_wr_n    (io_wr_n)
  );

  always_comb begin
    addr = '0;
    for (int i = 0; i < NCH; i++) begin
      if (bus_en && sel[i]) addr = ch_addr[i];
    end
  end

  assign done      = |term_vec;
  assign mask_stat = mask_vec;

  // R2
  masked_no_dack_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(|dack) |-> (|($past(pend) & dack)));

  // R1
  strb_in_dack_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!mem_rd_n || !mem_wr_n) |-> ((dack != '0) && (dack == $past(dack))));

  // R3
  strb_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!io_rd_n || !io_wr_n) |-> (hold && hlda));
endmodule

// File: tb/dma4_ctrl_bench.sv
module dma4_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_we = 1'b0;
  logic [1:0]  prog_chan = '0;
  logic [2:0]  prog_sel = '0;
  logic [15:0] prog_data = '0;
  logic [3:0]  dreq = '0;
  logic [3:0]  dack;
  logic        hold;
  logic        hlda = 1'b0;
  logic        hlda_block = 1'b0;
  logic [15:0] addr;
  logic        mem_rd_n, mem_wr_n, io_rd_n, io_wr_n;
  logic        eop_n = 1'b1;
  logic        done;
  logic [3:0]  tc_stat, mask_stat;

  int tests = 0, failed = 0, cyc = 0;
  int log_n = 0, done_cnt = 0, viol = 0, eop_at = -1;
  logic [15:0] log_addr [64];
  int          log_ch   [64];
  logic        log_td   [64];

  always #2 clk = ~clk;

  dma4_ctrl u_dma4_ctrl (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_chan(prog_chan),
    .prog_sel(prog_sel), .prog_data(prog_data), .dreq(dreq), .dack(dack),
    .hold(hold), .hlda(hlda), .addr(addr), .mem_rd_n(mem_rd_n),
    .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
    .eop_n(eop_n), .done(done), .tc_stat(tc_stat), .mask_stat(mask_stat)
  );

  // CPU bus-grant model
  always @(posedge clk) hlda <= hold & ~hlda_block;

  // transfer monitor
  always @(negedge clk) begin
    if (!mem_rd_n || !mem_wr_n) begin
      if (!hlda) viol++;
      if ((mem_wr_n != io_rd_n) || (mem_rd_n != io_wr_n)) viol++;
      eop_n = !(log_n == eop_at);
      if (log_n < 64) begin
        log_addr[log_n] = addr;
        log_td[log_n]   = !mem_rd_n;
        log_ch[log_n]   = -1;
        for (int k = 0; k < 4; k++) if (dack[k]) log_ch[log_n] = k;
      end
      log_n++;
    end else begin
      eop_n = 1'b1;
    end
    if (done) done_cnt++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      tests++;
      failed++;
      $display("FAIL watchdog (R3) actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic prog(input int ch, input int sel, input logic [15:0] d);
    @(negedge clk);
    prog_we   = 1'b1;
    prog_chan = ch[1:0];
    prog_sel  = sel[2:0];
    prog_data = d;
    @(negedge clk);
    prog_we   = 1'b0;
  endtask

  task automatic wait_done(input int target);
    int lim = 0;
    while (done_cnt < target && lim < 3000) begin
      @(negedge clk);
      #1;
      lim++;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic chk_xfer(input string tag, input int idx, input int ch,
                          input logic [15:0] a, input logic td);
    chk({tag, " addr"}, 32'(log_addr[idx]), 32'(a));
    chk({tag, " dack chan (R1)"}, 32'(log_ch[idx]), 32'(ch));
    chk({tag, " strobe pair (R11)"}, 32'(log_td[idx]), 32'(td));
  endtask

  // {pad[2:0], chan[1:0], mode[2:0] (autoinit,dec,to_dev), count[7:0], base[15:0]}
  localparam logic [31:0] VEC [4] = '{
    {3'b0, 2'd0, 3'b000, 8'd2, 16'h1000},
    {3'b0, 2'd1, 3'b001, 8'd0, 16'h20F0},
    {3'b0, 2'd2, 3'b010, 8'd3, 16'h0002},
    {3'b0, 2'd3, 3'b011, 8'd1, 16'hABCD}
  };

  initial begin
    int start, d0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R12 reset state
    chk("R12 hold", 32'(hold), 0);
    chk("R12 dack", 32'(dack), 0);
    chk("R12 strobes", 32'({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}), 32'hF);
    chk("R12 mask_stat", 32'(mask_stat), 32'hF);
    chk("R12 tc_stat", 32'(tc_stat), 0);
    chk("R12 done", 32'(done), 0);

    // table walk: R4 R5 R7 R11
    foreach (VEC[v]) begin
      int ch, cnt;
      logic [2:0] md;
      logic [15:0] base;
      ch = int'(VEC[v][28:27]); md = VEC[v][26:24];
      cnt = int'(VEC[v][23:16]); base = VEC[v][15:0];
      prog(ch, 0, base);
      prog(ch, 1, 16'(cnt));
      prog(ch, 2, {13'b0, md});
      prog(ch, 3, 16'h0000);
      start = log_n; d0 = done_cnt;
      @(negedge clk); dreq[ch] = 1'b1;
      wait_done(d0 + 1);
      dreq[ch] = 1'b0;
      idle(6);
      chk("R4 block length", 32'(log_n - start), 32'(cnt + 1));
      for (int i = 0; i <= cnt; i++)
        chk_xfer(md[1] ? "R5 vec" : "R4 vec", start + i, ch,
                 md[1] ? 16'(base - 16'(i)) : 16'(base + 16'(i)), md[0]);
      chk("R7 tc set", 32'(tc_stat[ch]), 1);
      chk("R7 mask set", 32'(mask_stat[ch]), 1);
      chk("R7 done count", 32'(done_cnt - d0), 1);
      chk("R3 hold dropped", 32'(hold), 0);
    end

    // R6 auto-reload
    prog(0, 0, 16'h0100);
    prog(0, 1, 16'd1);
    chk("R7 count write clears tc", 32'(tc_stat[0]), 0);
    prog(0, 2, 16'h0004);
    prog(0, 3, 16'h0000);
    start = log_n; d0 = done_cnt;
    @(negedge clk); dreq[0] = 1'b1;
    wait_done(d0 + 1);
    dreq[0] = 1'b0;
    idle(6);
    chk("R6 mask stays clear", 32'(mask_stat[0]), 0);
    chk("R6 tc set", 32'(tc_stat[0]), 1);
    @(negedge clk); dreq[0] = 1'b1;
    wait_done(d0 + 2);
    dreq[0] = 1'b0;
    idle(6);
    chk("R6 transfers", 32'(log_n - start), 4);
    for (int i = 0; i < 4; i++)
      chk_xfer("R6 reload", start + i, 0, 16'h0100 + 16'(i % 2), 1'b0);

    // R10 priority
    prog(1, 0, 16'h0300); prog(1, 1, 16'd1); prog(1, 2, 16'h0000); prog(1, 3, 16'h0000);
    prog(2, 0, 16'h0400); prog(2, 1, 16'd1); prog(2, 2, 16'h0001); prog(2, 3, 16'h0000);
    start = log_n; d0 = done_cnt;
    @(negedge clk); dreq[1] = 1'b1; dreq[2] = 1'b1;
    wait_done(d0 + 2);
    dreq = '0;
    idle(6);
    chk("R10 transfers", 32'(log_n - start), 4);
    chk_xfer("R10 first", start, 1, 16'h0300, 1'b0);
    chk_xfer("R10 second", start + 1, 1, 16'h0301, 1'b0);
    chk_xfer("R10 third", start + 2, 2, 16'h0400, 1'b1);
    chk_xfer("R10 fourth", start + 3, 2, 16'h0401, 1'b1);

    // R9 software request, cleared at block end (auto-reload keeps mask clear)
    prog(2, 0, 16'h0500); prog(2, 1, 16'd0); prog(2, 2, 16'h0004); prog(2, 3, 16'h0000);
    start = log_n; d0 = done_cnt;
    prog(2, 4, 16'h0001);
    wait_done(d0 + 1);
    idle(40);
    chk("R9 one transfer only", 32'(log_n - start), 1);
    chk_xfer("R9 soft", start, 2, 16'h0500, 1'b0);
    chk("R9 mask clear", 32'(mask_stat[2]), 0);
    prog(2, 3, 16'h0001);

    // R3 grant withheld
    hlda_block = 1'b1;
    prog(0, 0, 16'h0600); prog(0, 1, 16'd0); prog(0, 2, 16'h0000); prog(0, 3, 16'h0000);
    start = log_n; d0 = done_cnt;
    prog(0, 4, 16'h0001);
    idle(30);
    chk("R3 hold raised", 32'(hold), 1);
    chk("R3 no transfer before hlda", 32'(log_n - start), 0);
    hlda_block = 1'b0;
    wait_done(d0 + 1);
    idle(6);
    chk("R3 transfer after hlda", 32'(log_n - start), 1);
    chk_xfer("R3 xfer", start, 0, 16'h0600, 1'b0);

    // R8 early end
    prog(3, 0, 16'h0700); prog(3, 1, 16'd5); prog(3, 2, 16'h0001); prog(3, 3, 16'h0000);
    start = log_n; d0 = done_cnt;
    eop_at = start + 1;
    @(negedge clk); dreq[3] = 1'b1;
    wait_done(d0 + 1);
    dreq[3] = 1'b0;
    eop_at = -1;
    idle(20);
    chk("R8 transfers", 32'(log_n - start), 2);
    chk_xfer("R8 last", start + 1, 3, 16'h0701, 1'b1);
    chk("R8 tc", 32'(tc_stat[3]), 1);
    chk("R8 mask", 32'(mask_stat[3]), 1);

    // R2 masked channel ignored, then served once unmasked
    prog(1, 0, 16'h0800); prog(1, 1, 16'd0); prog(1, 2, 16'h0000); prog(1, 3, 16'h0001);
    start = log_n; d0 = done_cnt;
    @(negedge clk); dreq[1] = 1'b1;
    idle(40);
    chk("R2 masked no transfer", 32'(log_n - start), 0);
    chk("R2 masked no hold", 32'(hold), 0);
    prog(1, 3, 16'h0000);
    wait_done(d0 + 1);
    dreq[1] = 1'b0;
    idle(6);
    chk("R2 unmasked served", 32'(log_n - start), 1);

    chk("R3 R11 strobe without grant or bad pairing", 32'(viol), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule